// File: doc/BRIEF.md
# Serial Channel Interrupt Merge

This block folds the four interrupt causes of one serial channel into a single interrupt line for the chip's interrupt controller. Each cause latches into a source register bit. A mask register hides chosen causes. A pending register holds the unmasked causes, and the interrupt output is the OR of the pending bits. Software clears causes by writing ones, either to the source register or to the pending register.

The block also holds the FIFO-control word that sets the transmit interrupt policy. While the FIFO is enabled, the transmit cause sets itself on every cycle in which the transmit FIFO fill level is at or below a threshold. The threshold is a 3-bit field scaled by a factor that depends on the channel number, which is a build-time parameter. The FIFO storage and the data paths are outside this block. The transmit fill count arrives on an input port.

Top module: `sio_irq_merge`

## Requirements
- R1: After a synchronous reset, the control, source, mask and pending registers all read 0 and `irq` is low.
- R2: A one-cycle pulse on an event input sets its source bit after that clock edge. The bit positions are receive data 0, error 1, transmit 2 and modem 3. Source reads at address 1, bits [3:0].
- R3: The pending register (address 3, bits [3:0]) equals the source register AND NOT the mask register (address 2, bits [3:0]). It updates on the same edge as either register.
- R4: `irq` is high exactly when at least one pending bit is set, and it changes on the same edge as the pending register.
- R5: Writing to address 3 clears, in both the source and the pending registers, each bit whose data bit is 1. Bits written as 0 keep their value.
- R6: Writing to address 1 clears each source bit whose data bit is 1. Bits written as 0 keep their value.
- R7: If an event and a clearing write reach the same source bit in the same cycle, the bit ends up set.
- R8: The control register sits at address 0: bit 0 is the FIFO enable, bits [6:4] the receive trigger field and bits [10:8] the transmit trigger field. These bits read back as written and all other bits read 0.
- R9: While the FIFO enable is 1 and `tx_count` is at or below the transmit field times the channel factor, the transmit source bit is set on every edge. The factor is 32 for channel 0, 8 for channels 1 and 4, 2 for channels 2 and 3, and 0 for any other channel.
- R10: While the FIFO enable is 0, `tx_count` has no effect on the transmit source bit.
- R11: A read strobe returns the addressed register on `rd_data`, with `rd_valid` high, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| tx_count | input | CNT_W | Current transmit FIFO fill level |
| ev_rx | input | 1 | Receive data event |
| ev_err | input | 1 | Error event |
| ev_tx | input | 1 | Transmit event |
| ev_modem | input | 1 | Modem status event |
| irq | output | 1 | Merged interrupt, registered |

## Verification
The bench probes the transmit threshold at its edge: the count equal to the scaled field and the count one above it. A design that used a strict compare, or that scaled the field by the wrong factor, would set or miss the transmit cause at these points. It also clears the transmit cause while the FIFO is still below the threshold and expects the cause to come straight back. A one-shot implementation would leave the cause cleared. In the race case, a clear and an event reach the same bit in one cycle; a design that gave the clear priority would lose the event. The tests with masked causes and with writes to the pending register show whether the pending bits, the source bits and the line stay in step. A design that cleared only the pending copy would see the interrupt come back on the next edge.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  localparam int NUM_SRC = 4;

  // source bit positions
  localparam int SRC_RX    = 0;
  localparam int SRC_ERR   = 1;
  localparam int SRC_TX    = 2;
  localparam int SRC_MODEM = 3;

  // register addresses
  localparam logic [1:0] A_CFG  = 2'd0;
  localparam logic [1:0] A_SRC  = 2'd1;
  localparam logic [1:0] A_MASK = 2'd2;
  localparam logic [1:0] A_PEND = 2'd3;

  // control word field positions
  localparam int CFG_EN_BIT = 0;
  localparam int CFG_RX_LO  = 4;
  localparam int CFG_TX_LO  = 8;
  localparam int TRIG_W     = 3;

  typedef struct packed {
    logic              fifo_en;
    logic [TRIG_W-1:0] rx_trig;
    logic [TRIG_W-1:0] tx_trig;
  } cfg_t;

  // multiplier applied to the transmit trigger field
  function automatic int chan_factor(input int ch);
    case (ch)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/sio_irq_thresh.sv
module sio_irq_thresh
  import sio_irq_pkg::*;
#(
  parameter int CHANNEL = 0,
  parameter int CNT_W   = 8
) (
  input  logic              fifo_en,
  input  logic [TRIG_W-1:0] tx_trig,
  input  logic [CNT_W-1:0]  tx_count,
  output logic              tx_hit
);
  localparam int FACTOR = chan_factor(CHANNEL);
  localparam int CMP_W  = ((CNT_W > 8) ? CNT_W : 8) + 1;

  logic [CMP_W-1:0] thr;
  logic [CMP_W-1:0] cnt_ext;

  generate
    if (FACTOR == 0) begin : g_zero
      assign thr = '0;
    end else begin : g_scaled
      localparam logic [CMP_W-1:0] FAC = CMP_W'(FACTOR);
      assign thr = CMP_W'(tx_trig) * FAC;
    end
  endgenerate

  assign cnt_ext = CMP_W'(tx_count);
  assign tx_hit  = fifo_en && (cnt_ext <= thr);

endmodule

// File: rtl/sio_irq_srcreg.sv
module sio_irq_srcreg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] src_q,
  output logic [N-1:0] src_n
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      // a set in the same cycle as a clear takes priority
      assign src_n[i] = set_v[i] | (src_q[i] & ~clr_v[i]);
      always_ff @(posedge clk) begin
        if (rst) src_q[i] <= 1'b0;
        else     src_q[i] <= src_n[i];
      end
    end
  endgenerate
endmodule

// File: rtl/sio_irq_cfg.sv
module sio_irq_cfg
  import sio_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int N      = NUM_SRC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [N-1:0]      src_q,
  input  logic [N-1:0]      pend_q,
  output cfg_t              cfg_q,
  output logic [N-1:0]      mask_q,
  output logic [N-1:0]      mask_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic wr_cfg, wr_mask;
  logic [DATA_W-1:0] rd_mux;

  assign wr_cfg  = wr_en && (addr[1:0] == A_CFG);
  assign wr_mask = wr_en && (addr[1:0] == A_MASK);
  assign mask_n  = wr_mask ? wr_data[N-1:0] : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_q.fifo_en <= wr_data[CFG_EN_BIT];
        cfg_q.rx_trig <= wr_data[CFG_RX_LO +: TRIG_W];
        cfg_q.tx_trig <= wr_data[CFG_TX_LO +: TRIG_W];
      end
      mask_q <= mask_n;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr[1:0])
      A_CFG: begin
        rd_mux[CFG_EN_BIT]             = cfg_q.fifo_en;
        rd_mux[CFG_RX_LO +: TRIG_W]    = cfg_q.rx_trig;
        rd_mux[CFG_TX_LO +: TRIG_W]    = cfg_q.tx_trig;
      end
      A_SRC:   rd_mux[N-1:0] = src_q;
      A_MASK:  rd_mux[N-1:0] = mask_q;
      default: rd_mux[N-1:0] = pend_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/sio_irq_merge.sv
module sio_irq_merge
  import sio_irq_pkg::*;
#(
  parameter int CHANNEL = 0,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 2,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              ev_rx,
  input  logic              ev_err,
  input  logic              ev_tx,
  input  logic              ev_modem,
  output logic              irq
);
  localparam int N = NUM_SRC;

  cfg_t         cfg_q;
  logic [N-1:0] mask_q, mask_n;
  logic [N-1:0] src_q, src_n;
  logic [N-1:0] pend_q, pend_n;
  logic [N-1:0] set_v, clr_v;
  logic         tx_hit;
  logic         clr_by_src, clr_by_pend;

  sio_irq_thresh #(.CHANNEL(CHANNEL), .CNT_W(CNT_W)) thresh_i (
    .fifo_en (cfg_q.fifo_en),
    .tx_trig (cfg_q.tx_trig),
    .tx_count(tx_count),
    .tx_hit  (tx_hit)
  );

  always_comb begin
    set_v            = '0;
    set_v[SRC_RX]    = ev_rx;
    set_v[SRC_ERR]   = ev_err;
    set_v[SRC_TX]    = ev_tx | tx_hit;
    set_v[SRC_MODEM] = ev_modem;
  end

  assign clr_by_src  = wr_en && (addr[1:0] == A_SRC);
  assign clr_by_pend = wr_en && (addr[1:0] == A_PEND);
  assign clr_v       = (clr_by_src || clr_by_pend) ? wr_data[N-1:0] : '0;

  sio_irq_srcreg #(.N(N)) src_i (
    .clk  (clk),
    .rst  (rst),
    .set_v(set_v),
    .clr_v(clr_v),
    .src_q(src_q),
    .src_n(src_n)
  );

  sio_irq_cfg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N(N)) cfg_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wr_data (wr_data),
    .src_q   (src_q),
    .pend_q  (pend_q),
    .cfg_q   (cfg_q),
    .mask_q  (mask_q),
    .mask_n  (mask_n),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );

  assign pend_n = src_n & ~mask_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq    <= 1'b0;
    end else begin
      pend_q <= pend_n;
      irq    <= |pend_n;
    end
  end
endmodule

// File: rtl/sio_irq_merge_chk.sv
module sio_irq_merge_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_valid,
  input logic              ev_rx,
  input logic              ev_err,
  input logic              ev_modem,
  input logic              irq,
  input logic [3:0]        src_q,
  input logic [3:0]        mask_q,
  input logic [3:0]        pend_q,
  input logic              tx_hit
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (src_q == 4'd0) && (pend_q == 4'd0) && !irq);

  assert_rx_sets_R2: assert property (@(posedge clk) disable iff (rst)
    ev_rx |=> src_q[0]);

  assert_pend_match_R3: assert property (@(posedge clk) disable iff (rst)
    pend_q == (src_q & ~mask_q));

  assert_irq_match_R4: assert property (@(posedge clk) disable iff (rst)
    irq == (pend_q != 4'd0));

  assert_src_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[1:0] == 2'd1 && wr_data[3] && !ev_modem) |=> !src_q[3]);

  assert_event_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[1:0] == 2'd3 && wr_data[1] && ev_err) |=> src_q[1]);

  assert_tx_level_R9: assert property (@(posedge clk) disable iff (rst)
    tx_hit |=> src_q[2]);

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

bind sio_irq_merge sio_irq_merge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wr_data (wr_data),
  .rd_valid(rd_valid),
  .ev_rx   (ev_rx),
  .ev_err  (ev_err),
  .ev_modem(ev_modem),
  .irq     (irq),
  .src_q   (src_q),
  .mask_q  (mask_q),
  .pend_q  (pend_q),
  .tx_hit  (tx_hit)
);

// File: tb/sio_irq_merge_tb.sv
module sio_irq_merge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid;
  logic [CNT_W-1:0]  tx_count = 8'd255;
  logic              ev_rx = 1'b0, ev_err = 1'b0, ev_tx = 1'b0, ev_modem = 1'b0;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_irq_merge #(.CHANNEL(0), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .tx_count(tx_count), .ev_rx(ev_rx), .ev_err(ev_err), .ev_tx(ev_tx),
    .ev_modem(ev_modem), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check("R11 rd_valid", {31'd0, rd_valid}, 32'd1);
    d = rd_data;
  endtask

  task automatic pulse(input logic [3:0] ev);
    @(negedge clk);
    {ev_modem, ev_tx, ev_err, ev_rx} = ev;
    @(negedge clk);
    {ev_modem, ev_tx, ev_err, ev_rx} = 4'd0;
  endtask

  task automatic cleanup();
    tx_count = 8'd255;
    reg_wr(2'd0, 32'd0);
    reg_wr(2'd2, 32'd0);
    reg_wr(2'd3, 32'hF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'd0, irq}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      reg_rd(a[1:0], d);
      check("R1 reg zero", d, 32'd0);
    end
  endtask

  task automatic t_events();
    logic [31:0] d;
    pulse(4'b0001);
    reg_rd(2'd1, d); check("R2 rx bit0", d, 32'h1);
    check("R4 irq after rx", {31'd0, irq}, 32'd1);
    pulse(4'b1010);
    reg_rd(2'd1, d); check("R2 err+modem bits", d, 32'hB);
    pulse(4'b0100);
    reg_rd(2'd3, d); check("R3 pend all", d, 32'hF);
    cleanup();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    reg_wr(2'd2, 32'h1);
    pulse(4'b0001);
    reg_rd(2'd1, d); check("R3 src with mask", d, 32'h1);
    reg_rd(2'd3, d); check("R3 pend masked", d, 32'h0);
    check("R4 irq masked", {31'd0, irq}, 32'd0);
    reg_wr(2'd2, 32'h0);
    check("R4 irq unmasked", {31'd0, irq}, 32'd1);
    reg_rd(2'd3, d); check("R3 pend unmasked", d, 32'h1);
    reg_rd(2'd2, d); check("R8 mask readback", d, 32'h0);
    cleanup();
  endtask

  task automatic t_clear_pend();
    logic [31:0] d;
    pulse(4'b1001);
    reg_wr(2'd3, 32'h1);
    reg_rd(2'd1, d); check("R5 src after pend clear", d, 32'h8);
    reg_rd(2'd3, d); check("R5 pend after pend clear", d, 32'h8);
    reg_wr(2'd3, 32'h8);
    check("R5 irq low", {31'd0, irq}, 32'd0);
    cleanup();
  endtask

  task automatic t_clear_src();
    logic [31:0] d;
    pulse(4'b0110);
    reg_wr(2'd1, 32'h4);
    reg_rd(2'd1, d); check("R6 src after src clear", d, 32'h2);
    reg_rd(2'd3, d); check("R6 pend follows", d, 32'h2);
    cleanup();
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse(4'b0001);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wr_data = 32'h3; ev_err = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; ev_err = 1'b0;
    reg_rd(2'd1, d); check("R7 event beats clear", d, 32'h2);
    cleanup();
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    reg_wr(2'd0, 32'hFFFF_F8F0);
    reg_rd(2'd0, d); check("R8 cfg readback", d, 32'h0000_0070);
    reg_wr(2'd0, 32'h0000_0600);
    reg_rd(2'd0, d); check("R8 cfg tx field", d, 32'h0000_0600);
    cleanup();
  endtask

  task automatic t_auto_tx();
    logic [31:0] d;
    tx_count = 8'd33;
    reg_wr(2'd0, 32'h101);          // enable, tx field 1 -> threshold 32
    @(negedge clk);
    reg_rd(2'd1, d); check("R9 count above threshold", d, 32'h0);
    tx_count = 8'd32;
    @(negedge clk);
    reg_rd(2'd1, d); check("R9 count equals threshold", d, 32'h4);
    reg_wr(2'd3, 32'h4);
    reg_rd(2'd1, d); check("R9 reasserts after clear", d, 32'h4);
    check("R9 irq", {31'd0, irq}, 32'd1);
    tx_count = 8'd255;
    reg_wr(2'd3, 32'h4);
    reg_rd(2'd1, d); check("R9 stays clear above", d, 32'h0);
    reg_wr(2'd0, 32'h001);          // field 0 -> threshold 0
    tx_count = 8'd1;
    @(negedge clk);
    reg_rd(2'd1, d); check("R9 field0 count1", d, 32'h0);
    tx_count = 8'd0;
    @(negedge clk);
    reg_rd(2'd1, d); check("R9 field0 count0", d, 32'h4);
    cleanup();
  endtask

  task automatic t_auto_tx_off();
    logic [31:0] d;
    reg_wr(2'd0, 32'h700);          // field 7, enable off
    tx_count = 8'd0;
    repeat (3) @(negedge clk);
    reg_rd(2'd1, d); check("R10 disabled no tx", d, 32'h0);
    check("R10 irq low", {31'd0, irq}, 32'd0);
    cleanup();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_events();
    t_mask();
    t_clear_pend();
    t_clear_src();
    t_race();
    t_cfg();
    t_auto_tx();
    t_auto_tx_off();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule